// File: doc/BRIEF.md
# Timer Capture Unit with Byte-Wide Atomic Access

This block pairs a free-running 16-bit counter with a capture register. It sits on an 8-bit processor register bus. When the selected event input rises, the counter value is copied into the capture register and a capture flag is raised. The event can come from an external pin or from a comparator output. The capture value can also act as the wrap limit of the counter, which turns the counter into a period generator whose period software sets through the capture register.

Both 16-bit registers cross the 8-bit bus through one shared holding register for the upper byte. A read of a low byte also latches the matching upper byte into the holding register, so a later read of the upper byte returns the value from the same instant. A write of an upper byte only fills the holding register. The following low-byte write then commits all 16 bits in one cycle. An interrupt request is raised from the capture flag, gated by a mask bit and by a global enable input.

Top module: `tcap_unit`

## Requirements
- R1: The counter advances by one on every clock and rolls from 0xFFFF to 0x0000 when limit mode is off. A committed write loads it with the written value.
- R2: An event seen at the block's input is detected on the second clock edge after the input rises. On the next edge, the capture register takes the counter value that was present during the detection cycle.
- R3: Bit 0 of the control register (address 6) selects the event source: 0 selects the pin and 1 selects the comparator output. Edges on the source that is not selected cause no capture.
- R4: Each rising edge of the selected source causes exactly one capture. Holding the source high causes no further capture.
- R5: A read of a low byte (address 0 for the counter, address 2 for the capture register) returns the live low half. In the same cycle, the upper half is copied into the holding register. A read of the upper byte address (1 or 3) returns the holding register.
- R6: A write to address 1 or 3 changes only the holding register. A write to the low byte (address 0 or 2) loads {holding, written byte} into the target register in one cycle.
- R7: When bit 1 of the control register is set, the counter goes to zero on the clock after it equals the capture value.
- R8: The capture flag is bit 5 of the flag register (address 5) and is set by a capture. Writing 1 to bit 5 clears it and writing 0 leaves it set. A capture in the same cycle as a clear leaves it set.
- R9: The interrupt output is high exactly when the capture flag, bit 5 of the mask register (address 4, all 8 bits read/write) and the global enable input are all high.
- R10: After reset, the counter, capture, mask, flag, control and holding registers are all zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| cap_pin | input | 1 | External event input (asynchronous) |
| cmp_out | input | 1 | Comparator event input (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
The bench reads the counter low byte just before the upper byte rolls over, then reads the upper byte a few cycles later. A design without a real holding register would return the new upper byte there. It places a flag clear on the same edge as a capture; a design with the wrong priority loses that event. It holds the pin high across a flag clear, which catches a level-sensitive capture through a flag that comes back. It also checks that a lone upper-byte write leaves the capture register untouched, and that limit mode wraps at the capture value and not one count later.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int BUS_W = 8;
  localparam logic [2:0] A_CNT_L  = 3'd0;
  localparam logic [2:0] A_CNT_H  = 3'd1;
  localparam logic [2:0] A_CAP_L  = 3'd2;
  localparam logic [2:0] A_CAP_H  = 3'd3;
  localparam logic [2:0] A_MASK   = 3'd4;
  localparam logic [2:0] A_FLAG   = 3'd5;
  localparam logic [2:0] A_CTRL   = 3'd6;
  localparam int CAP_BIT = 5;
  localparam int SEL_BIT = 0;
  localparam int LIM_BIT = 1;
endpackage

// File: rtl/tcap_evt.sv
module tcap_evt #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic cmp,
  input  logic sel_cmp,
  output logic evt
);
  logic       src;
  logic [STAGES-1:0] sync_q;
  logic       prev_q;

  assign src = sel_cmp ? cmp : pin;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= src;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign evt = sync_q[STAGES-1] & ~prev_q;

  assert_one_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/tcap_cnt.sv
module tcap_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         lim_en,
  input  logic [W-1:0] lim_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    if (ld)                          cnt_d = ld_val;
    else if (lim_en && cnt == lim_val) cnt_d = '0;
    else                             cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assert_wrap_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_en && cnt == lim_val && !ld) |=> cnt == '0);
  assert_free_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_en && !ld) |=> cnt == W'($past(cnt) + W'(1)));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             cap_pin,
  input  logic             cmp_out,
  input  logic             gie,
  output logic             cap_irq
);
  localparam int CW = 2 * BUS_W;

  logic [CW-1:0]    cnt, cap_q, cap_d;
  logic [BUS_W-1:0] hold_q, hold_d, mask_q, mask_d;
  logic             flag_q, flag_d;
  logic [1:0]       ctrl_q, ctrl_d;
  logic             evt, cnt_ld;

  tcap_evt #(.STAGES(SYNC_STAGES)) u_evt (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .cmp(cmp_out),
    .sel_cmp(ctrl_q[SEL_BIT]), .evt(evt)
  );

  assign cnt_ld = bus_wr && bus_addr == A_CNT_L;

  tcap_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_val({hold_q, bus_wdata}),
    .lim_en(ctrl_q[LIM_BIT]), .lim_val(cap_q), .cnt(cnt)
  );

  always_comb begin
    hold_d = hold_q;
    cap_d  = cap_q;
    mask_d = mask_q;
    ctrl_d = ctrl_q;
    flag_d = flag_q;
    if (bus_wr) begin
      case (bus_addr)
        A_CNT_H, A_CAP_H: hold_d = bus_wdata;
        A_CAP_L:          cap_d  = {hold_q, bus_wdata};
        A_MASK:           mask_d = bus_wdata;
        A_CTRL:           ctrl_d = bus_wdata[1:0];
        A_FLAG:           if (bus_wdata[CAP_BIT]) flag_d = 1'b0;
        default: ;
      endcase
    end else if (bus_rd) begin
      if (bus_addr == A_CNT_L)      hold_d = cnt[CW-1:BUS_W];
      else if (bus_addr == A_CAP_L) hold_d = cap_q[CW-1:BUS_W];
    end
    if (evt) begin
      cap_d  = cnt;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cap_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      cap_q  <= cap_d;
      mask_q <= mask_d;
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_L:          bus_rdata = cnt[BUS_W-1:0];
      A_CAP_L:          bus_rdata = cap_q[BUS_W-1:0];
      A_CNT_H, A_CAP_H: bus_rdata = hold_q;
      A_MASK:           bus_rdata = mask_q;
      A_FLAG:           bus_rdata[CAP_BIT] = flag_q;
      A_CTRL:           bus_rdata[1:0] = ctrl_q;
      default: ;
    endcase
  end

  assign cap_irq = flag_q & mask_q[CAP_BIT] & gie;

  assert_cap_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap_q == $past(cnt));
  assert_flag_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  assert_hold_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == A_CAP_L) |=> hold_q == $past(cap_q[CW-1:BUS_W]));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> (gie && flag_q));
  assert_hi_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CAP_H && !evt) |=> $stable(cap_q));
endmodule

// File: tb/tcap_unit_test.sv
module tcap_unit_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       cap_pin = 1'b0, cmp_out = 1'b0, gie = 1'b0, cap_irq;

  int unsigned cyc = 0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] act_v;
  event        got_ev;

  tcap_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin), .cmp_out(cmp_out),
    .gie(gie), .cap_irq(cap_irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the oldest expected item and compares it with the observed one
  always begin
    @(got_ev);
    n_run++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL %s: actual %h expected <none>", "scoreboard", act_v);
    end else begin
      automatic logic [15:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      if (act_v !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, act_v, e);
      end
    end
  end

  task automatic expect_val(input string tag, input logic [15:0] e, input logic [15:0] a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    act_v = a;
    -> got_ev;
    #0;
  endtask

  int unsigned wr_edge;
  int unsigned rd_cyc;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    wr_edge = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    rd_cyc = cyc;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  int unsigned pulse_n;
  task automatic pulse(input bit use_cmp);
    @(negedge clk);
    if (use_cmp) cmp_out = 1'b1; else cap_pin = 1'b1;
    pulse_n = cyc;
    @(negedge clk);
    cmp_out = 1'b0; cap_pin = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b, lo8;
    logic [15:0] v, cap_exp;
    int unsigned e0, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(3'd4, b); expect_val("R10 mask", 16'h0, {8'h0, b});
    rd(3'd5, b); expect_val("R10 flag", 16'h0, {8'h0, b});
    rd16(3'd2, v); expect_val("R10 capture", 16'h0, v);
    expect_val("R10 irq", 16'h0, {15'h0, cap_irq});

    // R6/R5/R1: counter write then atomic read across the upper-byte rollover
    wr(3'd1, 8'h12); wr(3'd0, 8'hFE); e0 = wr_edge;
    rd(3'd0, lo8); c0 = rd_cyc;
    expect_val("R1 count low", 16'((16'h12FE + (c0 - e0)) & 16'hFF), {8'h0, lo8});
    idle(1);
    rd(3'd1, b);
    expect_val("R5 atomic high", 16'((16'h12FE + (c0 - e0)) >> 8), {8'h0, b});

    // R2/R8: capture from pin
    wr(3'd1, 8'h40); wr(3'd0, 8'h00); e0 = wr_edge;
    pulse(1'b0);
    cap_exp = 16'(16'h4000 + pulse_n + 2 - e0);
    idle(3);
    rd16(3'd2, v); expect_val("R2 capture value", cap_exp, v);
    wr(3'd5, 8'h00);
    rd(3'd5, b); expect_val("R8 zero write keeps flag", 16'h20, {8'h0, b});

    // R9 gating
    wr(3'd4, 8'hA5); rd(3'd4, b); expect_val("R9 mask readback", 16'hA5, {8'h0, b});
    gie = 1'b1; #1 expect_val("R9 irq all set", 16'h1, {15'h0, cap_irq});
    gie = 1'b0; #1 expect_val("R9 irq no gie", 16'h0, {15'h0, cap_irq});
    gie = 1'b1;
    wr(3'd4, 8'hDF); #1 expect_val("R9 irq masked", 16'h0, {15'h0, cap_irq});
    wr(3'd4, 8'h20);
    wr(3'd5, 8'h20);
    rd(3'd5, b); expect_val("R8 clear", 16'h00, {8'h0, b});
    #1 expect_val("R9 irq no flag", 16'h0, {15'h0, cap_irq});

    // R8 collision: clear committed on the capture edge
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); e0 = wr_edge;
    pulse(1'b0);
    cap_exp = 16'(pulse_n + 2 - e0);
    wr(3'd5, 8'h20);
    rd(3'd5, b); expect_val("R8 event beats clear", 16'h20, {8'h0, b});
    rd16(3'd2, v); expect_val("R2 capture in collision", cap_exp, v);
    wr(3'd5, 8'h20);

    // R6: upper-byte write alone leaves capture unchanged
    wr(3'd3, 8'hAB);
    rd16(3'd2, v); expect_val("R6 high write only", cap_exp, v);
    wr(3'd3, 8'hAB); wr(3'd2, 8'hCD);
    rd16(3'd2, v); expect_val("R6 pair commit", 16'hABCD, v);

    // R3: comparator source
    wr(3'd6, 8'h01);
    pulse(1'b0); idle(4);
    rd(3'd5, b); expect_val("R3 pin ignored", 16'h00, {8'h0, b});
    rd16(3'd2, v); expect_val("R3 capture kept", 16'hABCD, v);
    wr(3'd1, 8'h30); wr(3'd0, 8'h00); e0 = wr_edge;
    pulse(1'b1);
    cap_exp = 16'(16'h3000 + pulse_n + 2 - e0);
    idle(3);
    rd16(3'd2, v); expect_val("R3 comparator capture", cap_exp, v);
    wr(3'd5, 8'h20); wr(3'd6, 8'h00);

    // R4: level held high gives one capture only
    wr(3'd1, 8'h50); wr(3'd0, 8'h00); e0 = wr_edge;
    @(negedge clk); cap_pin = 1'b1; pulse_n = cyc;
    cap_exp = 16'(16'h5000 + pulse_n + 2 - e0);
    idle(4);
    wr(3'd5, 8'h20);
    idle(6);
    rd(3'd5, b); expect_val("R4 no recapture", 16'h00, {8'h0, b});
    rd16(3'd2, v); expect_val("R4 single capture", cap_exp, v);
    @(negedge clk); cap_pin = 1'b0;
    idle(4);

    // R7: limit mode wraps after capture value
    wr(3'd3, 8'h00); wr(3'd2, 8'h05);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); e0 = wr_edge;
    wr(3'd6, 8'h02);
    idle(3);
    rd(3'd0, lo8); c0 = rd_cyc;
    expect_val("R7 wrap at limit", 16'((c0 - e0) % 6), {8'h0, lo8});
    idle(2);
    rd(3'd0, lo8); c0 = rd_cyc;
    expect_val("R7 wrap again", 16'((c0 - e0) % 6), {8'h0, lo8});

    idle(2);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule